// File: doc/BRIEF.md
# Early-Acknowledge Invalidate Queue

This block sits beside the tag-state array of a small private cache. It takes coherence invalidate requests from the interconnect and acknowledges each one a cycle after accepting it, without first removing the line. The request goes into a short FIFO and the line is flagged as doomed. The real invalidation (state to invalid, flag cleared) happens later, one entry per clock, oldest first. That happens when the array port is free, when a barrier is draining, or when a local outbound message is waiting on a doomed line.

A line held in modified or exclusive state is dropped to shared in the same edge that accepts the invalidate, so the acknowledge never leaves with an owned copy behind it. Local loads may still hit on a doomed line. A rising barrier request stops loads and new invalidates until the queue is empty, and reports completion with a one-cycle done pulse. A fill port installs line states. It stands in for the rest of the cache controller.

State encoding used throughout: invalid = 0, shared = 1, exclusive = 2, modified = 3. The queue depth must be a power of two.

Top module: `inv_queue_ctrl`

## Requirements
- R1: After reset every line reads state 0 (invalid) with the doomed flag clear, the queue is empty, inv_ready is 1 and bar_done is 0.
- R2: A fill writes fill_state (0 invalid, 1 shared, 2 exclusive, 3 modified) into fill_line at the next edge. A fill to a doomed line, or to the line of an invalidate accepted in the same cycle, is ignored.
- R3: An invalidate is accepted when inv_valid and inv_ready are both 1. inv_ack is 1 in exactly the following cycle, and the line reads doomed from that cycle until its entry drains.
- R4: An accepted invalidate on a line in state 2 or 3 leaves it in state 1 by the acknowledge cycle. Lines in state 0 or 1 keep their state.
- R5: With ld_valid and ld_ready high, ld_hit is 1 whenever the addressed line is not invalid, including while it is doomed. ld_state and ld_doomed show the addressed line.
- R6: The queue holds 4 entries. When it is full, inv_ready is 0, and an offered invalidate gets no acknowledge and changes no line.
- R7: An invalidate for a line that is already doomed is acknowledged but adds no queue entry.
- R8: The queue drains one entry per clock, oldest first, only while arr_free is 1, a barrier is active, or a message is stalled. A drained line becomes invalid with its doomed flag clear.
- R9: msg_ready is 0 while msg_line is doomed and 1 otherwise. A stalled message forces draining until its line has been applied.
- R10: From the cycle after bar_req rises, ld_ready and inv_ready are 0 until the barrier completes. bar_done is 1 for one cycle, in the first such cycle with an empty queue. With N entries queued at the rise and arr_free low, that is N cycles after the first blocked cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_valid | input | 1 | Invalidate request offered |
| inv_line | input | AW | Line index of the invalidate |
| inv_ready | output | 1 | Invalidate can be accepted |
| inv_ack | output | 1 | Acknowledge, one cycle after acceptance |
| ld_valid | input | 1 | Local load lookup |
| ld_line | input | AW | Line index of the load |
| ld_ready | output | 1 | Loads may be served (low during a barrier) |
| ld_hit | output | 1 | Load hits a non-invalid line |
| ld_state | output | 2 | State of the load's line |
| ld_doomed | output | 1 | Load's line has a queued invalidate |
| msg_valid | input | 1 | Local outbound coherence message pending |
| msg_line | input | AW | Line the message concerns |
| msg_ready | output | 1 | Message may be sent now |
| fill_valid | input | 1 | Install a line state |
| fill_line | input | AW | Line index of the fill |
| fill_state | input | 2 | State to install |
| arr_free | input | 1 | State-array port free for a queued invalidate |
| bar_req | input | 1 | Barrier request (rising edge starts a drain) |
| bar_done | output | 1 | Barrier complete pulse |

## Verification
Lookups, message readiness, inv_ready and bar_done are combinational on registered state. The bench therefore reads them a couple of nanoseconds after the edge that updated that state, in the same cycle the stimulus is driven. inv_ack and every line-state change are registered once, so the bench checks them in the cycle after the accepting edge, and each drain is checked one edge at a time. The barrier latency is counted edge by edge from the first blocked cycle and compared with the number of entries queued at the rise.

// File: rtl/inv_queue_ctrl.sv
`timescale 1ns/1ps
module inv_queue_ctrl #(
  parameter int LINES = 8,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(LINES),
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inv_valid,
  input  logic [AW-1:0] inv_line,
  output logic          inv_ready,
  output logic          inv_ack,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_line,
  output logic          ld_ready,
  output logic          ld_hit,
  output logic [1:0]    ld_state,
  output logic          ld_doomed,
  input  logic          msg_valid,
  input  logic [AW-1:0] msg_line,
  output logic          msg_ready,
  input  logic          fill_valid,
  input  logic [AW-1:0] fill_line,
  input  logic [1:0]    fill_state,
  input  logic          arr_free,
  input  logic          bar_req,
  output logic          bar_done
);
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1;

  logic [1:0]       st [LINES];
  logic [LINES-1:0] doomed;
  logic [AW-1:0]    q [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             bar_q, bar_act, ack_q;

  wire empty     = (cnt == '0);
  wire full      = (cnt == CW'(DEPTH));
  wire inv_acc   = inv_valid && inv_ready;
  wire inv_new   = inv_acc && !doomed[inv_line];
  wire msg_stall = msg_valid && doomed[msg_line];
  wire drain     = !empty && (arr_free || bar_act || msg_stall);
  wire [AW-1:0] head = q[rp];
  wire fill_ok   = fill_valid && !doomed[fill_line] && !(inv_acc && inv_line == fill_line);

  assign inv_ready = !full && !bar_act;
  assign inv_ack   = ack_q;
  assign ld_ready  = !bar_act;
  assign ld_state  = st[ld_line];
  assign ld_doomed = doomed[ld_line];
  assign ld_hit    = ld_valid && ld_ready && (st[ld_line] != ST_I);
  assign msg_ready = !doomed[msg_line];
  assign bar_done  = bar_act && empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st[i] <= ST_I;
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
      doomed  <= '0;
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      bar_q   <= 1'b0;
      bar_act <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      ack_q   <= inv_acc;
      bar_q   <= bar_req;
      bar_act <= (bar_act && !bar_done) || (bar_req && !bar_q);
      if (fill_ok) st[fill_line] <= fill_state;
      if (inv_acc && st[inv_line][1]) st[inv_line] <= ST_S;
      if (inv_new) begin
        q[wp]            <= inv_line;
        wp               <= wp + 1'b1;
        doomed[inv_line] <= 1'b1;
      end
      if (drain) begin
        st[head]     <= ST_I;
        doomed[head] <= 1'b0;
        rp           <= rp + 1'b1;
      end
      cnt <= cnt + CW'(inv_new) - CW'(drain);
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R3
  ack_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_acc |=> inv_ack);

  // R4
  downgrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_acc |=> (st[$past(inv_line)] == ST_I || st[$past(inv_line)] == ST_S));

  // R10
  barrier_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_act && !empty) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: tb/inv_queue_ctrl_test.sv
`timescale 1ns/1ps
module inv_queue_ctrl_test;
  localparam int AW = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic inv_valid = 0, ld_valid = 0, msg_valid = 0, fill_valid = 0, arr_free = 0, bar_req = 0;
  logic [AW-1:0] inv_line = 0, ld_line = 0, msg_line = 0, fill_line = 0;
  logic [1:0] fill_state = 0;
  logic inv_ready, inv_ack, ld_ready, ld_hit, ld_doomed, msg_ready, bar_done;
  logic [1:0] ld_state;
  int total = 0, bad = 0;
  bit ended = 0;

  inv_queue_ctrl #(.LINES(8), .DEPTH(4)) uut (
    .clk, .rst_n, .inv_valid, .inv_line, .inv_ready, .inv_ack,
    .ld_valid, .ld_line, .ld_ready, .ld_hit, .ld_state, .ld_doomed,
    .msg_valid, .msg_line, .msg_ready, .fill_valid, .fill_line, .fill_state,
    .arr_free, .bar_req, .bar_done);

  always #4 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic look(int l);
    ld_line = AW'(l); #1;
  endtask

  task automatic fill(int l, int s);
    fill_valid = 1; fill_line = AW'(l); fill_state = 2'(s);
    step(); fill_valid = 0;
  endtask

  task automatic inv(int l);
    inv_valid = 1; inv_line = AW'(l);
    step(); inv_valid = 0; #1;
    chk("R3 ack", int'(inv_ack), 1);
    look(l);
    chk("R3 doomed", int'(ld_doomed), 1);
  endtask

  task automatic done_up();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1600000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done_up();
  end

  initial begin
    int n;
    repeat (3) step();
    rst_n = 1; ld_valid = 1; step();
    for (int i = 0; i < 8; i++) begin
      look(i);
      chk("R1 state", int'(ld_state), 0);
      chk("R1 doomed", int'(ld_doomed), 0);
    end
    chk("R1 ready", int'(inv_ready), 1);
    chk("R1 bar_done", int'(bar_done), 0);

    for (int i = 0; i < 8; i++) fill(i, i % 4);
    for (int i = 0; i < 8; i++) begin
      look(i);
      chk("R2 fill", int'(ld_state), i % 4);
      chk("R5 hit", int'(ld_hit), int'(i % 4 != 0));
    end

    inv(3); chk("R4 M->S", int'(ld_state), 1); chk("R5 doomed hit", int'(ld_hit), 1);
    inv(2); chk("R4 E->S", int'(ld_state), 1);
    inv(1); chk("R4 S kept", int'(ld_state), 1);
    inv(3); chk("R7 dup keeps room", int'(inv_ready), 1);
    inv(0); chk("R4 I kept", int'(ld_state), 0);
    chk("R6 full", int'(inv_ready), 0);

    inv_valid = 1; inv_line = 5; step(); inv_valid = 0; #1;
    chk("R6 no ack", int'(inv_ack), 0);
    look(5);
    chk("R6 state", int'(ld_state), 1);
    chk("R6 doomed", int'(ld_doomed), 0);

    fill(3, 3); look(3);
    chk("R2 fill ignored", int'(ld_state), 1);
    step(); look(3);
    chk("R8 lazy", int'(ld_doomed), 1);

    msg_valid = 1; msg_line = 6; #1;
    chk("R9 other line", int'(msg_ready), 1);
    msg_line = 1; #1;
    chk("R9 stall", int'(msg_ready), 0);
    step(); look(3);
    chk("R8 drain state", int'(ld_state), 0);
    chk("R8 drain flag", int'(ld_doomed), 0);
    chk("R9 still", int'(msg_ready), 0);
    step(); chk("R9 still", int'(msg_ready), 0);
    step(); chk("R9 released", int'(msg_ready), 1);
    msg_valid = 0;
    look(0); chk("R8 order", int'(ld_doomed), 1);

    fill(5, 3); fill(6, 2);
    inv(5); chk("R4 M->S", int'(ld_state), 1);
    inv(6); chk("R4 E->S", int'(ld_state), 1);
    bar_req = 1; step();
    chk("R10 ld blocked", int'(ld_ready), 0);
    chk("R10 inv blocked", int'(inv_ready), 0);
    chk("R10 not done", int'(bar_done), 0);
    n = 0;
    while (!bar_done && n < 10) begin step(); n++; end
    chk("R10 latency", n, 3);
    step();
    chk("R10 pulse", int'(bar_done), 0);
    chk("R10 ld back", int'(ld_ready), 1);
    foreach (uut.doomed[k]) ;
    look(0); chk("R8 barrier drain", int'(ld_state), 0);
    look(5); chk("R8 barrier drain", int'(ld_state), 0);
    look(6); chk("R8 barrier drain", int'(ld_doomed), 0);

    bar_req = 0; step(); bar_req = 1; step();
    chk("R10 empty done", int'(bar_done), 1);
    step(); chk("R10 empty pulse", int'(bar_done), 0);
    bar_req = 0;

    inv(1); inv(2);
    arr_free = 1; step(); arr_free = 0;
    look(1); chk("R8 arr drain", int'(ld_doomed), 0);
    look(2); chk("R8 one per clock", int'(ld_doomed), 1);
    arr_free = 1; step(); arr_free = 0;
    look(2); chk("R8 arr drain", int'(ld_doomed), 0);

    done_up();
  end
endmodule